// File: doc/BRIEF.md
# I2C Channel Selector Register

This block is a serial-bus target that controls which of four downstream bus segments is connected to the upstream controller. It samples SCL and SDA on the system clock and detects start and stop conditions on those samples. It recognises its own 7-bit address and keeps one control byte. A controller writes that byte to choose one channel or none, and reads it back to see which channels have an interrupt pending. The outputs are a one-hot channel-enable vector for the external pass switches and an enable that pulls SDA low through an open-drain pad.

A write stores the selection at once. The enable outputs move to the new value only when the next stop condition is seen, so a segment is never connected or cut off in the middle of a transfer. A read returns the live state of the four active-low interrupt lines in the upper nibble and the stored selection in the low bits. The system clock must run at least 16 times faster than SCL. A synchronous reset takes the place of a power-on reset.

Top module: `i2c_chan_selector`

## Requirements
- R1: The target address is binary 1110 followed by the strap inputs (bit 2 down to bit 0), and the eighth bit is R/W, where 1 means read. On a match the target pulls SDA low for the ninth clock. On a mismatch it never pulls SDA low, and it ignores the bus until the next start or stop.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start that arrives partway through a byte abandons that byte and restarts address reception. A stop releases SDA.
- R3: In a write, every data byte is acknowledged with SDA low on its ninth clock. When several bytes are written in one transfer, the last one received is the one kept.
- R4: The selection is the low three bits of the control byte. If bit 2 is 0, no channel is enabled. If bit 2 is 1, bits 1:0 give the index of the enabled channel (chan_en_o bit index = that value). The upper five bits written are ignored. At most one chan_en_o bit is ever high.
- R5: A written selection reaches chan_en_o only after the next stop condition. A repeated start does not apply it.
- R6: A read byte is sent MSB first and changes only while SCL is low. It carries {~irq_n_i[3], ~irq_n_i[2], ~irq_n_i[1], ~irq_n_i[0], 0, stored selection[2:0]}, sampled when the byte is loaded. The target releases SDA for the controller's acknowledge. An ACK there sends another byte, and a NACK ends the read.
- R7: Reset clears the stored and the applied selection to zero, so chan_en_o is 0, and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL level as seen at the pad |
| sda_i | input | 1 | SDA level as seen at the pad |
| strap_i | input | 3 | Low three address bits, tied off on the board |
| irq_n_i | input | 4 | Active-low interrupt line of each channel |
| sda_drive_o | output | 1 | 1 = pull SDA low through the open-drain pad |
| chan_en_o | output | 4 | One-hot enable of the downstream channels, all zero for none |

## Verification
The assertions rely on the controller changing SDA only while SCL is low, except to signal start or stop. They also rely on every SCL level lasting far longer than the synchronizer delay. Under those two conditions, any rising edge of the SDA drive falls in an SCL low phase, and a change of the channel enables can be traced to a stop detected one cycle earlier. The bench works a bit-level controller model with each quarter bit lasting 16 clocks. It changes SDA only at the quarter point of the low phase and changes the interrupt lines only between transfers, so every check lands on settled levels.

// File: rtl/i2c_chan_pkg.sv
package i2c_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

    localparam int BYTE_W = 8;
    localparam int DEV_ADDR_W = 7;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sh   = {smp_q.scl_sh[STAGES-2:0], scl_i};
        smp_d.sda_sh   = {smp_q.sda_sh[STAGES-2:0], sda_i};
        smp_d.scl_prev = smp_q.scl_sh[STAGES-1];
        smp_d.sda_prev = smp_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    // Edge and condition pulses use the synchronized level and the one before it
    assign scl_lvl   = smp_q.scl_sh[STAGES-1];
    assign sda_lvl   = smp_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~smp_q.scl_prev;
    assign scl_fall  = ~scl_lvl & smp_q.scl_prev;
    assign start_det = smp_q.scl_prev & scl_lvl & smp_q.sda_prev & ~sda_lvl;
    assign stop_det  = smp_q.scl_prev & scl_lvl & ~smp_q.sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_chan_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b1110,
    parameter int         NUM_CH      = 4,
    parameter int         SEL_W       = 3,
    localparam int        STRAP_W     = DEV_ADDR_W - 4,
    localparam int        CNT_W       = $clog2(BYTE_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [NUM_CH-1:0]  irq_n,
    input  logic [SEL_W-1:0]   stored_sel,
    output logic               sel_wr_en,
    output logic [SEL_W-1:0]   sel_wr_data,
    output logic               sda_drive
);

    typedef struct packed {
        tgt_state_e        state;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] txreg;
        logic [CNT_W-1:0]  cnt;
        logic              rw;
        logic              ctl_ack;
        logic              drive;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [BYTE_W-1:0] rd_byte;
    logic              addr_hit;
    logic              byte_done;

    always_comb begin
        rd_byte                          = '0;
        rd_byte[BYTE_W-1 -: NUM_CH]      = ~irq_n;
        rd_byte[SEL_W-1:0]               = stored_sel;
    end

    assign addr_hit  = (f_q.shreg[BYTE_W-1:1] == {ADDR_PREFIX, strap});
    assign byte_done = (f_q.cnt == CNT_W'(BYTE_W));

    always_comb begin
        f_d         = f_q;
        sel_wr_en   = 1'b0;
        sel_wr_data = f_q.shreg[SEL_W-1:0];
        if (start_det) begin
            f_d.state = ST_ADDR;
            f_d.cnt   = '0;
            f_d.drive = 1'b0;
        end else if (stop_det) begin
            f_d.state = ST_IDLE;
            f_d.cnt   = '0;
            f_d.drive = 1'b0;
        end else begin
            unique case (f_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        f_d.shreg = {f_q.shreg[BYTE_W-2:0], sda_lvl};
                        f_d.cnt   = f_q.cnt + 1'b1;
                    end else if (scl_fall && byte_done) begin
                        if (addr_hit) begin
                            f_d.state = ST_ADDR_ACK;
                            f_d.drive = 1'b1;
                            f_d.rw    = f_q.shreg[0];
                        end else begin
                            f_d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        f_d.cnt = '0;
                        if (f_q.rw) begin
                            f_d.state = ST_RD_DATA;
                            f_d.txreg = rd_byte;
                            f_d.drive = ~rd_byte[BYTE_W-1];
                        end else begin
                            f_d.state = ST_WR_DATA;
                            f_d.drive = 1'b0;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        f_d.shreg = {f_q.shreg[BYTE_W-2:0], sda_lvl};
                        f_d.cnt   = f_q.cnt + 1'b1;
                    end else if (scl_fall && byte_done) begin
                        sel_wr_en = 1'b1;
                        f_d.state = ST_WR_ACK;
                        f_d.drive = 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        f_d.state = ST_WR_DATA;
                        f_d.cnt   = '0;
                        f_d.drive = 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise) begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            f_d.state = ST_RD_ACK;
                            f_d.drive = 1'b0;
                        end else begin
                            f_d.txreg = {f_q.txreg[BYTE_W-2:0], 1'b0};
                            f_d.drive = ~f_q.txreg[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        f_d.ctl_ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (f_q.ctl_ack) begin
                            f_d.state = ST_RD_DATA;
                            f_d.cnt   = '0;
                            f_d.txreg = rd_byte;
                            f_d.drive = ~rd_byte[BYTE_W-1];
                        end else begin
                            f_d.state = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    f_d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q       <= '0;
            f_q.state <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_drive = f_q.drive;

endmodule

// File: rtl/i2c_chan_ctrl.sv
module i2c_chan_ctrl #(
    parameter int  IDX_W  = 2,
    localparam int NUM_CH = 1 << IDX_W,
    localparam int SEL_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              stop_det,
    output logic [SEL_W-1:0]  stored_sel,
    output logic [NUM_CH-1:0] chan_en
);

    typedef struct packed {
        logic [SEL_W-1:0] pending;
        logic [SEL_W-1:0] active;
    } sel_t;

    sel_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.pending = wr_sel;
        end
        // Connection changes wait for a stop so every segment sees an idle bus
        if (stop_det) begin
            s_d.active = wr_en ? wr_sel : s_q.pending;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stored_sel = s_q.pending;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        assign chan_en[ch] = s_q.active[IDX_W] && (s_q.active[IDX_W-1:0] == IDX_W'(ch));
    end

endmodule

// File: rtl/i2c_chan_selector.sv
module i2c_chan_selector #(
    parameter logic [3:0] ADDR_PREFIX = 4'b1110,
    parameter int         IDX_W       = 2,
    parameter int         SYNC_STAGES = 2,
    localparam int        NUM_CH      = 1 << IDX_W,
    localparam int        SEL_W       = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic [NUM_CH-1:0] irq_n_i,
    output logic              sda_drive_o,
    output logic [NUM_CH-1:0] chan_en_o
);

    logic             scl_lvl;
    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             sel_wr_en;
    logic [SEL_W-1:0] sel_wr_data;
    logic [SEL_W-1:0] stored_sel;

    i2c_line_sampler #(
        .STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(
        .ADDR_PREFIX (ADDR_PREFIX),
        .NUM_CH      (NUM_CH),
        .SEL_W       (SEL_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_lvl     (sda_lvl),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .strap       (strap_i),
        .irq_n       (irq_n_i),
        .stored_sel  (stored_sel),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .sda_drive   (sda_drive_o)
    );

    i2c_chan_ctrl #(
        .IDX_W (IDX_W)
    ) u_chan (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (sel_wr_en),
        .wr_sel     (sel_wr_data),
        .stop_det   (stop_det),
        .stored_sel (stored_sel),
        .chan_en    (chan_en_o)
    );

endmodule

// File: rtl/i2c_chan_selector_chk.sv
module i2c_chan_selector_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              stop_det,
    input logic              sda_drive,
    input logic [NUM_CH-1:0] chan_en
);

    p_ack_on_low_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive) |-> !scl_lvl);

    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        $past(stop_det) |-> !sda_drive);

    p_chan_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_en));

    p_apply_on_stop_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(chan_en) |-> $past(stop_det));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (chan_en == '0 && !sda_drive));

endmodule

bind i2c_chan_selector i2c_chan_selector_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .stop_det  (stop_det),
    .sda_drive (sda_drive_o),
    .chan_en   (chan_en_o)
);

// File: tb/test_i2c_chan_selector.sv
module test_i2c_chan_selector;

    localparam int          CLK_PERIOD = 10;
    localparam int          QTR        = 16;
    localparam logic [2:0]  STRAP      = 3'b101;
    localparam logic [7:0]  ADDR_WR    = {4'b1110, STRAP, 1'b0};
    localparam logic [7:0]  ADDR_RD    = {4'b1110, STRAP, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_ctl = 1'b1;
    logic [3:0] irq_n = 4'hF;
    logic       sda_drive;
    logic [3:0] chan_en;
    wire        sda_bus = sda_ctl & ~sda_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_chan_selector i_i2c_chan_selector (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .strap_i     (STRAP),
        .irq_n_i     (irq_n),
        .sda_drive_o (sda_drive),
        .chan_en_o   (chan_en)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_ctl = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        sda_ctl = 1'b0; wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic bus_stop();
        sda_ctl = 1'b0; wait_q();
        scl = 1'b1;     wait_q();
        sda_ctl = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_ctl = b; wait_q();
        scl = 1'b1;  wait_q();
        wait_q();
        scl = 1'b0;  wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_ctl = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        b = sda_bus;    wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        acked = ~x;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic write_sel(input logic [7:0] v, input string req);
        logic ack;
        bus_start();
        send_byte(ADDR_WR, ack);
        check_eq(req, "address ack on write", int'(ack), 1);
        send_byte(v, ack);
        check_eq(req, "data ack", int'(ack), 1);
        bus_stop();
    endtask

    task automatic t_reset();
        check_eq("R7", "chan_en after reset", int'(chan_en), 0);
        check_eq("R7", "sda drive after reset", int'(sda_drive), 0);
    endtask

    task automatic t_write_apply();
        logic ack;
        bus_start();
        send_byte(ADDR_WR, ack);
        check_eq("R1", "ack on matching address", int'(ack), 1);
        send_byte(8'h05, ack);
        check_eq("R3", "ack on data byte", int'(ack), 1);
        check_eq("R5", "chan_en before stop", int'(chan_en), 0);
        bus_stop();
        check_eq("R4", "channel 1 enabled", int'(chan_en), 4'b0010);
    endtask

    task automatic t_multi_write();
        logic ack;
        bus_start();
        send_byte(ADDR_WR, ack);
        send_byte(8'h06, ack);
        send_byte(8'h07, ack);
        check_eq("R3", "ack on second data byte", int'(ack), 1);
        bus_stop();
        check_eq("R3", "last byte kept, channel 3", int'(chan_en), 4'b1000);
    endtask

    task automatic t_disable();
        write_sel(8'hF3, "R4");
        check_eq("R4", "bit2 clear disables all", int'(chan_en), 0);
    endtask

    task automatic t_wrong_addr();
        logic ack;
        bus_start();
        send_byte({4'b1110, 3'b010, 1'b0}, ack);
        check_eq("R1", "no ack on other address", int'(ack), 0);
        send_byte(8'h04, ack);
        check_eq("R1", "no ack while ignoring", int'(ack), 0);
        bus_stop();
        check_eq("R1", "ignored write leaves chan_en", int'(chan_en), 0);
    endtask

    task automatic t_read_status();
        logic       ack;
        logic [7:0] v;
        write_sel(8'h06, "R3");
        check_eq("R4", "channel 2 enabled", int'(chan_en), 4'b0100);
        irq_n = 4'b1010;
        bus_start();
        send_byte(ADDR_RD, ack);
        check_eq("R1", "ack on read address", int'(ack), 1);
        recv_byte(1'b0, v);
        check_eq("R6", "read byte irq 0 and 2", int'(v), 8'h56);
        check_eq("R6", "SDA released after NACK", int'(sda_bus), 1);
        bus_stop();
        irq_n = 4'b0111;
        bus_start();
        send_byte(ADDR_RD, ack);
        recv_byte(1'b1, v);
        check_eq("R6", "first of two bytes", int'(v), 8'h86);
        recv_byte(1'b0, v);
        check_eq("R6", "second byte after ACK", int'(v), 8'h86);
        bus_stop();
        irq_n = 4'hF;
    endtask

    task automatic t_read_pending();
        logic       ack;
        logic [7:0] v;
        bus_start();
        send_byte(ADDR_WR, ack);
        send_byte(8'h04, ack);
        bus_start();
        send_byte(ADDR_RD, ack);
        check_eq("R1", "ack after repeated start", int'(ack), 1);
        recv_byte(1'b0, v);
        check_eq("R6", "read shows stored selection", int'(v), 8'h04);
        check_eq("R5", "repeated start does not apply", int'(chan_en), 4'b0100);
        bus_stop();
        check_eq("R5", "stop applies channel 0", int'(chan_en), 4'b0001);
    endtask

    task automatic t_abort();
        logic ack;
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(ADDR_WR, ack);
        check_eq("R2", "address ack after aborted byte", int'(ack), 1);
        send_byte(8'h07, ack);
        bus_stop();
        check_eq("R2", "write after restart applied", int'(chan_en), 4'b1000);
        check_eq("R2", "SDA released after stop", int'(sda_drive), 0);
    endtask

    task automatic t_midrun_reset();
        logic       ack;
        logic [7:0] v;
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_eq("R7", "reset clears chan_en", int'(chan_en), 0);
        bus_start();
        send_byte(ADDR_RD, ack);
        recv_byte(1'b0, v);
        check_eq("R7", "reset clears stored selection", int'(v[2:0]), 0);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_apply();
        t_multi_write();
        t_disable();
        t_wrong_addr();
        t_read_status();
        t_read_pending();
        t_abort();
        t_midrun_reset();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule